// File: doc/BRIEF.md
# Trigger Routing Crossbar with Grouped Selector Lock

This block routes event pulses from a set of trigger sources to a set of trigger targets. Every target output is a combinational copy of one source input. A small selector register per target picks that source. Software programs the selectors through a simple register port. The port has a write strobe, a word address and 32-bit write data, and the read data for the addressed word is returned in the same cycle.

The selectors are packed four to a 32-bit configuration word, which serves four neighbouring targets. Each word also has one lock bit. Setting the lock freezes all four selectors in that word, and the word then stays frozen until reset. Locking one target therefore also locks the other three targets that share its word.

The target count is a parameter. It is rounded up to whole words, so the target output bus is four times the number of words wide.

Top module: `trig_xbar`

## Requirements
- R1: After reset every configuration word reads back as 0, so all selectors are 0 and all locks are clear.
- R2: Word g configures targets 4g to 4g+3. Target 4g+k takes its selector from bits 8k+7:8k for k = 0, 1 and 2, and from bits 30:24 for k = 3. A write to an unlocked word stores all 32 bits, and the stored value reads back from the next cycle on.
- R3: Bit 31 of a word is its lock. Writing 1 there sets the lock, and the lock then reads back as 1.
- R4: While a word is locked, every write to it is ignored. This covers all four selectors and any attempt to clear bit 31. Only reset clears the lock.
- R5: A lock affects only its own word. Writes to the other words still take effect.
- R6: Target output t equals trig_in[s] in the same cycle, where s is the selector of target t. A new selector value takes effect in the cycle after the write.
- R7: A selector value equal to or greater than NUM_SRC drives its target output to 0.
- R8: Any address at or above the number of words reads as 0, and writes to such an address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Write strobe for the configuration port |
| reg_addr | input | ADDR_W | Word address for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Contents of the addressed word, combinational |
| trig_in | input | NUM_SRC | Trigger source inputs |
| trig_out | output | 4*ceil(NUM_TGT/4) | Routed trigger target outputs |

## Verification
The properties that tie a write to the following contents of a word only look at cycles whose previous edge was outside reset. Every other property takes no assumption about the inputs, so random write strobes, addresses and data may arrive in any cycle. The stimulus picks addresses beyond the last word, selector bytes above the source count and occasional lock bits. It also applies a reset in the middle of the run, so the random phase does not end with every word frozen.

// File: rtl/trig_xbar_pkg.sv
package trig_xbar_pkg;

    localparam int WORD_W   = 32;
    localparam int SEL_W    = 8;
    localparam int PER_WORD = 4;

    // Layout of one configuration word; the field positions are decoded by
    // the target selector slicing in the top module.
    typedef struct packed {
        logic       lock;
        logic [6:0] sel3;
        logic [7:0] sel2;
        logic [7:0] sel1;
        logic [7:0] sel0;
    } grp_cfg_t;

endpackage

// File: rtl/trig_xbar_regs.sv
module trig_xbar_regs
    import trig_xbar_pkg::*;
#(
    parameter int NUM_GRP = 4,
    parameter int ADDR_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [WORD_W-1:0]         wdata,
    output logic [WORD_W-1:0]         rdata,
    output grp_cfg_t [NUM_GRP-1:0]    cfg_o
);

    typedef struct packed {
        grp_cfg_t [NUM_GRP-1:0] grp;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        rdata = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (addr == ADDR_W'(g)) begin
                rdata = st_q.grp[g];
                if (we && !st_q.grp[g].lock) begin
                    st_d.grp[g] = grp_cfg_t'(wdata);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.grp;

endmodule

// File: rtl/trig_xbar_mux.sv
module trig_xbar_mux
    import trig_xbar_pkg::*;
#(
    parameter int NUM_SRC = 40
) (
    input  logic [NUM_SRC-1:0] src,
    input  logic [SEL_W-1:0]   sel,
    output logic               y
);

    always_comb begin
        y = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel == SEL_W'(i)) begin
                y = src[i];
            end
        end
    end

endmodule

// File: rtl/trig_xbar.sv
module trig_xbar
    import trig_xbar_pkg::*;
#(
    parameter int NUM_TGT = 14,
    parameter int NUM_SRC = 40,
    parameter int ADDR_W  = 4,
    localparam int NUM_GRP = (NUM_TGT + PER_WORD - 1) / PER_WORD,
    localparam int NUM_TP  = NUM_GRP * PER_WORD
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    input  logic [NUM_SRC-1:0]   trig_in,
    output logic [NUM_TP-1:0]    trig_out
);

    grp_cfg_t [NUM_GRP-1:0]  cfg_w;
    logic     [SEL_W-1:0]    sel_w [NUM_TP];

    trig_xbar_regs #(
        .NUM_GRP (NUM_GRP),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg_o (cfg_w)
    );

    for (genvar t = 0; t < NUM_TP; t++) begin : g_tgt
        localparam int G = t / PER_WORD;
        localparam int K = t % PER_WORD;
        if (K == PER_WORD - 1) begin : g_top
            assign sel_w[t] = {1'b0, cfg_w[G].sel3};
        end else begin : g_low
            assign sel_w[t] = cfg_w[G][SEL_W*K +: SEL_W];
        end
        trig_xbar_mux #(
            .NUM_SRC (NUM_SRC)
        ) u_mux (
            .src (trig_in),
            .sel (sel_w[t]),
            .y   (trig_out[t])
        );
    end

endmodule

// File: rtl/trig_xbar_chk.sv
module trig_xbar_chk
    import trig_xbar_pkg::*;
#(
    parameter int NUM_GRP = 4,
    parameter int NUM_SRC = 40,
    parameter int ADDR_W  = 4,
    parameter int NUM_TP  = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   reg_we,
    input logic [ADDR_W-1:0]      reg_addr,
    input logic [WORD_W-1:0]      reg_wdata,
    input logic [WORD_W-1:0]      reg_rdata,
    input logic [NUM_TP-1:0]      trig_out,
    input grp_cfg_t [NUM_GRP-1:0] cfg
);

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(cfg[g].lock) |-> cfg[g].lock); // R4
        AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(cfg[g].lock) |-> $stable(cfg[g])); // R4
        AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(reg_we) && $past(reg_addr) == ADDR_W'(g) && !$past(cfg[g].lock)
            |-> cfg[g] == $past(reg_wdata)); // R2
        AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && !($past(reg_we) && $past(reg_addr) == ADDR_W'(g))
            |-> $stable(cfg[g])); // R5
    end

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr >= ADDR_W'(NUM_GRP) |-> reg_rdata == '0); // R8

    for (genvar t = 0; t < NUM_TP; t++) begin : g_out
        localparam int G = t / PER_WORD;
        localparam int K = t % PER_WORD;
        logic [SEL_W-1:0] s;
        if (K == PER_WORD - 1) begin : g_top
            assign s = {1'b0, cfg[G][30:24]};
        end else begin : g_low
            assign s = cfg[G][SEL_W*K +: SEL_W];
        end
        AST_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            int'(s) >= NUM_SRC |-> !trig_out[t]); // R7
    end

endmodule

bind trig_xbar trig_xbar_chk #(
    .NUM_GRP (NUM_GRP),
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .NUM_TP  (NUM_TP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .trig_out  (trig_out),
    .cfg       (cfg_w)
);

// File: tb/trig_xbar_tb_top.sv
module trig_xbar_tb_top;

    localparam int NTGT = 14;
    localparam int NSRC = 40;
    localparam int AW   = 4;
    localparam int NG   = (NTGT + 3) / 4;
    localparam int NTP  = NG * 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_we = 1'b0;
    logic [AW-1:0]    reg_addr = '0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic [NSRC-1:0]  trig_in = '0;
    logic [NTP-1:0]   trig_out;

    logic [31:0] model [NG];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    trig_xbar #(.NUM_TGT(NTGT), .NUM_SRC(NSRC), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .trig_in(trig_in), .trig_out(trig_out)
    );

    function automatic logic [31:0] exp_read(input int a);
        if (a >= NG) return 32'h0;
        return model[a];
    endfunction

    function automatic logic [NTP-1:0] exp_out(input logic [NSRC-1:0] src);
        logic [NTP-1:0] r = '0;
        for (int t = 0; t < NTP; t++) begin
            int g = t / 4;
            int k = t % 4;
            int s = (k == 3) ? int'(model[g][30:24]) : int'(model[g][8*k +: 8]);
            r[t] = (s < NSRC) ? src[s] : 1'b0;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        reg_we = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int g = 0; g < NG; g++) model[g] = 32'h0;
    endtask

    task automatic do_write(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_addr = AW'(a);
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (a < NG && !model[a][31]) model[a] = d;
    endtask

    task automatic check_read(input string req, input int a);
        reg_addr = AW'(a);
        #1;
        chk(req, {32'h0, reg_rdata}, {32'h0, exp_read(a)});
    endtask

    task automatic check_out(input string req, input logic [NSRC-1:0] src);
        trig_in = src;
        #1;
        chk(req, {{(64-NTP){1'b0}}, trig_out}, {{(64-NTP){1'b0}}, exp_out(src)});
    endtask

    function automatic logic [NSRC-1:0] rnd_src();
        logic [63:0] w = {$urandom(), $urandom()};
        return w[NSRC-1:0];
    endfunction

    initial begin
        void'($urandom(32'd1234));
        for (int g = 0; g < NG; g++) model[g] = 32'h0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < NG; a++) check_read("R1", a);
        check_out("R1", {NSRC{1'b1}});

        // R2/R6: plain routing, field positions
        do_write(0, 32'h27_05_10_00);
        check_read("R2", 0);
        check_out("R6", NSRC'(1) << 5);
        check_out("R6", NSRC'(1) << 39);
        check_out("R6", rnd_src());
        do_write(3, 32'h01_02_03_04);   // padding targets 14,15 routed too
        check_out("R6", NSRC'(4'hF) << 1);

        // R7: out-of-range selectors, including field 3 at 7 bits
        do_write(1, 32'h7F_FF_28_C8);
        check_read("R2", 1);
        check_out("R7", {NSRC{1'b1}});

        // R3/R4: lock word 2, then try to alter it
        do_write(2, 32'h8A_0B_0C_0D);
        check_read("R3", 2);
        do_write(2, 32'h00_00_00_00);
        check_read("R4", 2);
        check_out("R4", {NSRC{1'b1}});
        do_write(2, 32'h81_01_01_01);
        check_read("R4", 2);

        // R5: neighbours still writable
        do_write(1, 32'h11_12_13_14);
        check_read("R5", 1);
        check_out("R5", rnd_src());

        // R8: out-of-range address
        do_write(NG, 32'hFFFF_FFFF);
        do_write(15, 32'h1234_5678);
        check_read("R8", NG);
        check_read("R8", 15);
        for (int a = 0; a < NG; a++) check_read("R8", a);

        // R4: reset clears the lock
        do_reset();
        check_read("R4", 2);
        do_write(2, 32'h01_02_03_04);
        check_read("R4", 2);

        // random phase
        for (int it = 0; it < 600; it++) begin
            int op = int'($urandom_range(0, 3));
            if (it == 300) begin
                do_reset();
                for (int a = 0; a < NG; a++) check_read("R1", a);
            end
            if (op <= 1) begin
                logic [31:0] d = $urandom();
                d[31] = ($urandom_range(0, 15) == 0);
                do_write(int'($urandom_range(0, NG + 1)), d);
            end else if (op == 2) begin
                check_read("R2", int'($urandom_range(0, NG + 1)));
            end else begin
                check_out("R6", rnd_src());
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule